// File: doc/BRIEF.md
# I2C Message Transaction Sequencer

This block runs one I2C bus transaction made of up to four messages. It sits on top of a bit-level byte engine. Software-side logic fills a small descriptor array, one entry per message. Each entry holds a 7-bit or 10-bit target address, a direction, a byte count and three per-message options:

- tolerate NACKs;
- skip the start condition and address;
- read without acknowledge clocks.

A one-cycle `go` pulse starts the transaction. The sequencer then drives a one-command-at-a-time handshake to the byte engine: open, reopen (repeated START), close, write byte, read byte, acknowledge bit, and a long hold.

Bytes to transmit come from a valid/ready byte stream. Received bytes leave on a valid-only stream. When the closing STOP completes, the sequencer pulses `done` and reports a 2-bit result code together with the number of messages it completed.

Top module: `i2c_xact_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `bc_valid`, `tx_ready` and `rx_valid` are all low.
- R2: Each engine command is a single-cycle `bc_valid` pulse, and no further command is issued until `bc_done` has returned for the previous one. Operation codes on `bc_op`: 0 open, 1 reopen, 2 close, 3 write byte, 4 read byte, 5 acknowledge bit, 6 long hold.
- R3: For a 7-bit address, the address byte is the address in bits 7:1, with bit 0 set to 1 for a read and 0 for a write.
- R4: For a 10-bit address, two bytes are written. The first is 0xF0 with address bits 9:8 in bits 2:1 and bit 0 clear. The second is address bits 7:0. For a 10-bit read, once both bytes are accepted, a reopen follows, and then the first byte is written again with bit 0 set.
- R5: When an address byte (first or resent) is NACKed, the block retries it with the sequence close, long hold, open, and the same byte again. It makes `retry_limit`+1 attempts in total. If the last attempt is also NACKed, the block closes the bus with result code 1 (I/O error).
- R6: When a message's ignore-NACK option is set, only one address attempt is made, and neither address NACKs nor data NACKs abort the transaction.
- R7: A message with the skip-start option issues neither a reopen nor any address byte, and proceeds directly to its data.
- R8: During a read, each byte except the last is followed by an acknowledge-bit command with `bc_byte` = 1 (ACK). The last byte is followed by one with `bc_byte` = 0 (NACK). With the no-read-ACK option set, no acknowledge-bit command is issued.
- R9: When a data byte is NACKed during a write and ignore-NACK is clear, the block closes the bus with result code 2 (write error) and a count equal to the index of the failing message.
- R10: When `bc_timeout` is asserted with `bc_done`, the block closes the bus with result code 3 (timeout) and a count equal to the index of the current message.
- R11: Every transaction starts with an open, uses a reopen before each message after the first (unless skip-start is set), and ends with exactly one close. On success, `done` reports code 0 and a count equal to `go_count`, limited to the array depth. A count of 0 produces an open followed by a close.
- R12: A data byte is taken only while `tx_valid` is high: `tx_ready` pulses in the same cycle as the write command that carries that byte. The sequencer waits as long as the stream is empty. Each received byte appears for one cycle on `rx_data` with `rx_valid`.
- R13: A `go` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | AW | Descriptor slot written |
| cfg_addr | input | 10 | Target address (low 7 bits used in 7-bit mode) |
| cfg_ten | input | 1 | 10-bit addressing |
| cfg_rd | input | 1 | Message direction: 1 = read |
| cfg_len | input | LEN_W | Byte count |
| cfg_ign_nack | input | 1 | Tolerate NACKs, no retries |
| cfg_skip_start | input | 1 | No reopen and no address |
| cfg_no_rack | input | 1 | No acknowledge clocks on reads |
| go | input | 1 | Start pulse |
| go_count | input | CW | Number of messages |
| retry_limit | input | RETRY_W | Address retries after the first attempt |
| bc_valid | output | 1 | Engine command pulse |
| bc_op | output | 3 | Engine operation code |
| bc_byte | output | 8 | Write byte, or acknowledge value |
| bc_done | input | 1 | Engine finished the command |
| bc_nack | input | 1 | Written byte was NACKed |
| bc_timeout | input | 1 | Clock stretch timed out |
| bc_rbyte | input | 8 | Byte read by the engine |
| tx_data | input | 8 | Outgoing data byte |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Outgoing byte taken |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished |
| res_code | output | 2 | 0 ok, 1 I/O, 2 write, 3 timeout |
| res_count | output | CW | Messages completed |

## Verification
The main sequencing path is tried with several transaction shapes: a plain 7-bit write, a 7-bit read of several bytes, a 10-bit read, a 10-bit write followed by a skip-start write, and a write followed by a no-acknowledge read.

Comparing the exact engine command stream for each shape separates the address byte forms, the reopen placement and the ACK/NACK choice on the last read byte.

Scripted engine responses inject address NACKs that recover before the limit and NACKs that exhaust it, tolerated NACKs, a data NACK and a timeout. These distinguish the retry count and each error code.

An empty transmit stream, a second `go` during a transaction and a zero message count cover the flow-control and idle corners.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  typedef enum logic [2:0] {
    BC_OPEN    = 3'd0,
    BC_REOPEN  = 3'd1,
    BC_CLOSE   = 3'd2,
    BC_WRITE   = 3'd3,
    BC_READ    = 3'd4,
    BC_ACKBIT  = 3'd5,
    BC_HOLD    = 3'd6
  } bcmd_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_IO      = 2'd1,
    RES_WRITE   = 2'd2,
    RES_TIMEOUT = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_DECIDE, S_WAIT, S_DATA, S_TXWAIT, S_NEXT, S_FIN
  } state_e;

  typedef enum logic [3:0] {
    P_OPEN, P_REOPEN, P_ADDR, P_RSTOP, P_RHOLD, P_RSTART,
    P_WDATA, P_RDATA, P_RACK, P_CLOSE
  } phase_e;

  typedef enum logic [1:0] {
    A_FIRST, A_SECOND, A_RESEND
  } astep_e;
endpackage

// File: rtl/i2cq_desc_store.sv
module i2cq_desc_store #(
  parameter int DEPTH = 4,
  parameter int W     = 23,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2cq_addr_build.sv
module i2cq_addr_build (
  input  logic [9:0] addr,
  input  logic       ten,
  input  logic       rd,
  output logic [7:0] first_b,
  output logic [7:0] second_b,
  output logic [7:0] first_rd_b
);
  always_comb begin
    if (ten) first_b = {5'b11110, addr[9:8], 1'b0};
    else     first_b = {addr[6:0], rd};
    second_b   = addr[7:0];
    first_rd_b = first_b | 8'h01;
  end
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2cq_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int LEN_W   = 8,
  parameter int RETRY_W = 4,
  parameter int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW      = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_idx,
  input  logic [9:0]         cfg_addr,
  input  logic               cfg_ten,
  input  logic               cfg_rd,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_ign_nack,
  input  logic               cfg_skip_start,
  input  logic               cfg_no_rack,
  input  logic               go,
  input  logic [CW-1:0]      go_count,
  input  logic [RETRY_W-1:0] retry_limit,
  output logic               bc_valid,
  output logic [2:0]         bc_op,
  output logic [7:0]         bc_byte,
  input  logic               bc_done,
  input  logic               bc_nack,
  input  logic               bc_timeout,
  input  logic [7:0]         bc_rbyte,
  input  logic [7:0]         tx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  output logic               busy,
  output logic               done,
  output logic [1:0]         res_code,
  output logic [CW-1:0]      res_count
);
  localparam int F_ADDR   = LEN_W;
  localparam int F_TEN    = LEN_W + 10;
  localparam int F_RD     = LEN_W + 11;
  localparam int F_IGN    = LEN_W + 12;
  localparam int F_SKIP   = LEN_W + 13;
  localparam int F_NORACK = LEN_W + 14;
  localparam int DW       = LEN_W + 15;
  localparam logic [CW-1:0] MAXMSG = CW'(DEPTH);

  state_e             state;
  phase_e             phase;
  astep_e             astep;
  logic [CW-1:0]      midx, nmsg, cnt_q;
  logic [LEN_W-1:0]   rem;
  logic [RETRY_W-1:0] attempt, rlim, rlim_eff;
  res_e               code;
  logic [DW-1:0]      dsc;
  logic [7:0]         ab_first, ab_second, ab_first_rd;

  // descriptor fields of the current message
  logic [LEN_W-1:0] d_len;
  logic [9:0]       d_addr;
  logic d_ten, d_rd, d_ign, d_skip, d_norack;

  assign d_len    = dsc[LEN_W-1:0];
  assign d_addr   = dsc[F_ADDR+9:F_ADDR];
  assign d_ten    = dsc[F_TEN];
  assign d_rd     = dsc[F_RD];
  assign d_ign    = dsc[F_IGN];
  assign d_skip   = dsc[F_SKIP];
  assign d_norack = dsc[F_NORACK];
  assign rlim_eff = d_ign ? '0 : rlim;

  i2cq_desc_store #(.DEPTH(DEPTH), .W(DW), .AW(AW)) u_store (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_idx),
    .wdata ({cfg_no_rack, cfg_skip_start, cfg_ign_nack, cfg_rd, cfg_ten, cfg_addr, cfg_len}),
    .raddr (midx[AW-1:0]),
    .rdata (dsc)
  );

  i2cq_addr_build u_addr (
    .addr       (d_addr),
    .ten        (d_ten),
    .rd         (d_rd),
    .first_b    (ab_first),
    .second_b   (ab_second),
    .first_rd_b (ab_first_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      phase     <= P_OPEN;
      astep     <= A_FIRST;
      midx      <= '0;
      nmsg      <= '0;
      cnt_q     <= '0;
      rem       <= '0;
      attempt   <= '0;
      rlim      <= '0;
      code      <= RES_OK;
      bc_valid  <= 1'b0;
      bc_op     <= 3'd0;
      bc_byte   <= 8'd0;
      tx_ready  <= 1'b0;
      rx_data   <= 8'd0;
      rx_valid  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      res_code  <= 2'd0;
      res_count <= '0;
    end else begin
      bc_valid <= 1'b0;
      tx_ready <= 1'b0;
      rx_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          busy     <= 1'b1;
          midx     <= '0;
          nmsg     <= (go_count > MAXMSG) ? MAXMSG : go_count;
          rlim     <= retry_limit;
          code     <= RES_OK;
          cnt_q    <= '0;
          bc_valid <= 1'b1;
          bc_op    <= BC_OPEN;
          bc_byte  <= 8'd0;
          phase    <= P_OPEN;
          state    <= S_WAIT;
        end
        S_LOAD: state <= S_DECIDE;
        S_DECIDE: begin
          rem     <= d_len;
          attempt <= '0;
          astep   <= A_FIRST;
          if (d_skip) begin
            state <= S_DATA;
          end else if (midx != '0) begin
            bc_valid <= 1'b1; bc_op <= BC_REOPEN; bc_byte <= 8'd0;
            phase <= P_REOPEN; state <= S_WAIT;
          end else begin
            bc_valid <= 1'b1; bc_op <= BC_WRITE; bc_byte <= ab_first;
            phase <= P_ADDR; state <= S_WAIT;
          end
        end
        S_WAIT: if (bc_done) begin
          if (bc_timeout && phase != P_CLOSE) begin
            code <= RES_TIMEOUT; cnt_q <= midx;
            bc_valid <= 1'b1; bc_op <= BC_CLOSE; bc_byte <= 8'd0;
            phase <= P_CLOSE;
          end else begin
            case (phase)
              P_OPEN: begin
                if (nmsg == '0) begin
                  bc_valid <= 1'b1; bc_op <= BC_CLOSE; bc_byte <= 8'd0;
                  phase <= P_CLOSE;
                end else begin
                  state <= S_LOAD;
                end
              end
              P_REOPEN: begin
                bc_valid <= 1'b1; bc_op <= BC_WRITE;
                bc_byte  <= (astep == A_RESEND) ? ab_first_rd : ab_first;
                phase    <= P_ADDR;
              end
              P_ADDR: begin
                if (astep == A_SECOND) begin
                  if (!bc_nack || d_ign) begin
                    if (d_rd) begin
                      astep <= A_RESEND; attempt <= '0;
                      bc_valid <= 1'b1; bc_op <= BC_REOPEN; bc_byte <= 8'd0;
                      phase <= P_REOPEN;
                    end else begin
                      state <= S_DATA;
                    end
                  end else begin
                    code <= RES_IO; cnt_q <= midx;
                    bc_valid <= 1'b1; bc_op <= BC_CLOSE; bc_byte <= 8'd0;
                    phase <= P_CLOSE;
                  end
                end else if (!bc_nack || d_ign) begin
                  if (astep == A_FIRST && d_ten) begin
                    astep <= A_SECOND;
                    bc_valid <= 1'b1; bc_op <= BC_WRITE; bc_byte <= ab_second;
                  end else begin
                    state <= S_DATA;
                  end
                end else if (attempt < rlim_eff) begin
                  attempt <= attempt + 1'b1;
                  bc_valid <= 1'b1; bc_op <= BC_CLOSE; bc_byte <= 8'd0;
                  phase <= P_RSTOP;
                end else begin
                  code <= RES_IO; cnt_q <= midx;
                  bc_valid <= 1'b1; bc_op <= BC_CLOSE; bc_byte <= 8'd0;
                  phase <= P_CLOSE;
                end
              end
              P_RSTOP: begin
                bc_valid <= 1'b1; bc_op <= BC_HOLD; bc_byte <= 8'd0;
                phase <= P_RHOLD;
              end
              P_RHOLD: begin
                bc_valid <= 1'b1; bc_op <= BC_OPEN; bc_byte <= 8'd0;
                phase <= P_RSTART;
              end
              P_RSTART: begin
                bc_valid <= 1'b1; bc_op <= BC_WRITE;
                bc_byte  <= (astep == A_RESEND) ? ab_first_rd : ab_first;
                phase    <= P_ADDR;
              end
              P_WDATA: begin
                if (bc_nack && !d_ign) begin
                  code <= RES_WRITE; cnt_q <= midx;
                  bc_valid <= 1'b1; bc_op <= BC_CLOSE; bc_byte <= 8'd0;
                  phase <= P_CLOSE;
                end else begin
                  rem <= rem - 1'b1;
                  state <= S_DATA;
                end
              end
              P_RDATA: begin
                rx_valid <= 1'b1;
                rx_data  <= bc_rbyte;
                rem      <= rem - 1'b1;
                if (d_norack) begin
                  state <= S_DATA;
                end else begin
                  bc_valid <= 1'b1; bc_op <= BC_ACKBIT;
                  bc_byte  <= {7'd0, (rem != LEN_W'(1))};
                  phase    <= P_RACK;
                end
              end
              P_RACK:  state <= S_DATA;
              P_CLOSE: state <= S_FIN;
              default: state <= S_FIN;
            endcase
          end
        end
        S_DATA: begin
          if (rem == '0) begin
            state <= S_NEXT;
          end else if (d_rd) begin
            bc_valid <= 1'b1; bc_op <= BC_READ; bc_byte <= 8'd0;
            phase <= P_RDATA; state <= S_WAIT;
          end else begin
            state <= S_TXWAIT;
          end
        end
        S_TXWAIT: if (tx_valid) begin
          tx_ready <= 1'b1;
          bc_valid <= 1'b1; bc_op <= BC_WRITE; bc_byte <= tx_data;
          phase <= P_WDATA; state <= S_WAIT;
        end
        S_NEXT: begin
          if (midx + 1'b1 == nmsg) begin
            cnt_q <= nmsg;
            bc_valid <= 1'b1; bc_op <= BC_CLOSE; bc_byte <= 8'd0;
            phase <= P_CLOSE; state <= S_WAIT;
          end else begin
            midx  <= midx + 1'b1;
            state <= S_LOAD;
          end
        end
        S_FIN: begin
          done      <= 1'b1;
          busy      <= 1'b0;
          res_code  <= code;
          res_count <= cnt_q;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cq_chk.sv
module i2cq_chk
  import i2cq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       go,
  input logic       busy,
  input logic       done,
  input logic       bc_valid,
  input logic [2:0] bc_op,
  input logic [7:0] bc_byte,
  input logic       bc_done,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid
);
  logic       outstanding;
  logic [2:0] last_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
      last_op     <= 3'd0;
    end else begin
      if (bc_valid) begin
        outstanding <= 1'b1;
        last_op     <= bc_op;
      end else if (bc_done) begin
        outstanding <= 1'b0;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (!bc_valid && !tx_ready && !rx_valid));

  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    bc_valid |=> !bc_valid);

  a_r2_wait_for_done: assert property (@(posedge clk) disable iff (rst)
    (outstanding && !bc_done) |=> !bc_valid);

  a_r8_ackbit_form: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_op == BC_ACKBIT) |-> (bc_byte[7:1] == 7'd0));

  a_r11_close_before_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (last_op == BC_CLOSE));

  a_r12_tx_take: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (bc_valid && bc_op == BC_WRITE && $past(tx_valid) && bc_byte == $past(tx_data)));

  a_r13_go_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && go) |=> (busy || done));
endmodule

bind i2c_xact_seq i2cq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .go       (go),
  .busy     (busy),
  .done     (done),
  .bc_valid (bc_valid),
  .bc_op    (bc_op),
  .bc_byte  (bc_byte),
  .bc_done  (bc_done),
  .tx_data  (tx_data),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid)
);

// File: tb/tb_i2c_xact_seq.sv
module tb_i2c_xact_seq;
  import i2cq_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       cfg_we = 0, cfg_ten = 0, cfg_rd = 0, cfg_ign = 0, cfg_skip = 0, cfg_norack = 0;
  logic [1:0] cfg_idx = 0;
  logic [9:0] cfg_addr = 0;
  logic [7:0] cfg_len = 0;
  logic       go = 0;
  logic [2:0] go_count = 0;
  logic [3:0] retry_limit = 0;
  logic       bc_valid, bc_done = 0, bc_nack = 0, bc_timeout = 0;
  logic [2:0] bc_op;
  logic [7:0] bc_byte, bc_rbyte = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic       tx_valid = 0, tx_ready, rx_valid, busy, done;
  logic [1:0] res_code;
  logic [2:0] res_count;

  i2c_xact_seq dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
    .cfg_ten(cfg_ten), .cfg_rd(cfg_rd), .cfg_len(cfg_len), .cfg_ign_nack(cfg_ign),
    .cfg_skip_start(cfg_skip), .cfg_no_rack(cfg_norack), .go(go), .go_count(go_count),
    .retry_limit(retry_limit), .bc_valid(bc_valid), .bc_op(bc_op), .bc_byte(bc_byte),
    .bc_done(bc_done), .bc_nack(bc_nack), .bc_timeout(bc_timeout), .bc_rbyte(bc_rbyte),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .busy(busy), .done(done), .res_code(res_code), .res_count(res_count)
  );

  int n_chk = 0, n_fail = 0;
  int ecmd[$];
  int ebyte[$];
  string etag[$];
  logic [7:0] erx[$], grx[$], txq[$];
  bit nackq[$];
  int pend = 0, pend_no = 0, cmd_no = 0, to_at = -1;
  int pend_op = 0;
  logic [7:0] rd_next = 8'h30;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural byte engine and command comparison, all at the falling edge
  always @(negedge clk) begin
    bc_done = 0; bc_nack = 0; bc_timeout = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        bc_done = 1;
        if (pend_op == BC_WRITE && nackq.size() != 0) bc_nack = nackq.pop_front();
        if (pend_op == BC_READ) begin bc_rbyte = rd_next; rd_next++; end
        bc_timeout = (pend_no == to_at);
      end
    end
    if (bc_valid) begin
      cmd_no++;
      chk(pend == 0, "R2", "command issued while previous one pending", pend, 0);
      if (ecmd.size() == 0) begin
        chk(0, "R11", "unexpected extra command", bc_op, 7);
      end else begin
        automatic int e = ecmd.pop_front();
        automatic int b = ebyte.pop_front();
        automatic string t = etag.pop_front();
        chk(bc_op == e, t, "command op", bc_op, e);
        if (b >= 0) chk(bc_byte == b, t, "command byte", bc_byte, b);
      end
      pend = 3; pend_op = bc_op; pend_no = cmd_no;
    end
    if (tx_ready && txq.size() != 0) void'(txq.pop_front());
    tx_valid = (txq.size() != 0);
    tx_data  = tx_valid ? txq[0] : 8'h00;
    if (rx_valid) grx.push_back(rx_data);
  end

  task automatic ex(input int op, input int b, input string tag);
    ecmd.push_back(op); ebyte.push_back(b); etag.push_back(tag);
  endtask

  task automatic load(input int idx, input int addr, input bit ten, input bit rd, input int len,
                      input bit ign, input bit skip, input bit norack);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx[1:0]; cfg_addr = addr[9:0]; cfg_ten = ten; cfg_rd = rd;
    cfg_len = len[7:0]; cfg_ign = ign; cfg_skip = skip; cfg_norack = norack;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(input int cnt, input int rlim, input int exp_code, input int exp_cnt,
                     input string tag, input bit second_go, input int late_tx);
    int guard;
    @(negedge clk);
    go = 1; go_count = cnt[2:0]; retry_limit = rlim[3:0];
    @(negedge clk);
    go = 0;
    chk(busy == 1, tag, "busy after go", busy, 1);
    if (second_go) begin
      repeat (3) @(negedge clk);
      go = 1; go_count = 3'd4;
      @(negedge clk);
      go = 0;
      chk(busy == 1, "R13", "busy kept after second go", busy, 1);
    end
    if (late_tx >= 0) begin
      repeat (40) @(negedge clk);
      chk(cmd_no == 2, "R12", "commands issued while tx stream empty", cmd_no, 2);
      txq.push_back(late_tx[7:0]);
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(done == 1, tag, "transaction finished", done, 1);
    chk(res_code == exp_code[1:0], tag, "result code", res_code, exp_code);
    chk(res_count == exp_cnt[2:0], tag, "result count", res_count, exp_cnt);
    chk(ecmd.size() == 0, tag, "expected commands left over", ecmd.size(), 0);
    chk(grx.size() == erx.size(), tag, "received byte count", grx.size(), erx.size());
    for (int i = 0; i < erx.size() && i < grx.size(); i++)
      chk(grx[i] == erx[i], tag, "received byte", grx[i], erx[i]);
    repeat (2) @(negedge clk);
    chk(busy == 0, tag, "idle after done", busy, 0);
    ecmd.delete(); ebyte.delete(); etag.delete(); erx.delete(); grx.delete();
    txq.delete(); nackq.delete();
    cmd_no = 0; to_at = -1; rd_next = 8'h30;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!bc_valid && !tx_ready && !rx_valid, "R1", "strobes after reset", {bc_valid, tx_ready, rx_valid}, 0);

    // R3 7-bit write of two bytes
    load(0, 'h50, 0, 0, 2, 0, 0, 0);
    txq.push_back(8'hAA); txq.push_back(8'h55);
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'hA0, "R3"); ex(BC_WRITE, 'hAA, "R12");
    ex(BC_WRITE, 'h55, "R12"); ex(BC_CLOSE, -1, "R11");
    run(1, 0, 0, 1, "R3", 0, -1);

    // R8 7-bit read of three bytes, with R13 second go
    load(0, 'h21, 0, 1, 3, 0, 0, 0);
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'h43, "R3");
    ex(BC_READ, -1, "R8"); ex(BC_ACKBIT, 1, "R8");
    ex(BC_READ, -1, "R8"); ex(BC_ACKBIT, 1, "R8");
    ex(BC_READ, -1, "R8"); ex(BC_ACKBIT, 0, "R8");
    ex(BC_CLOSE, -1, "R11");
    erx.push_back(8'h30); erx.push_back(8'h31); erx.push_back(8'h32);
    run(1, 0, 0, 1, "R8", 1, -1);

    // R4 10-bit read
    load(0, 'h2A5, 1, 1, 1, 0, 0, 0);
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'hF4, "R4"); ex(BC_WRITE, 'hA5, "R4");
    ex(BC_REOPEN, -1, "R4"); ex(BC_WRITE, 'hF5, "R4");
    ex(BC_READ, -1, "R8"); ex(BC_ACKBIT, 0, "R8"); ex(BC_CLOSE, -1, "R11");
    erx.push_back(8'h30);
    run(1, 0, 0, 1, "R4", 0, -1);

    // R5 address retry that succeeds on the third attempt
    load(0, 'h50, 0, 0, 1, 0, 0, 0);
    txq.push_back(8'h11);
    nackq.push_back(1); nackq.push_back(1); nackq.push_back(0); nackq.push_back(0);
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'hA0, "R5");
    ex(BC_CLOSE, -1, "R5"); ex(BC_HOLD, -1, "R5"); ex(BC_OPEN, -1, "R5"); ex(BC_WRITE, 'hA0, "R5");
    ex(BC_CLOSE, -1, "R5"); ex(BC_HOLD, -1, "R5"); ex(BC_OPEN, -1, "R5"); ex(BC_WRITE, 'hA0, "R5");
    ex(BC_WRITE, 'h11, "R12"); ex(BC_CLOSE, -1, "R11");
    run(1, 2, 0, 1, "R5", 0, -1);

    // R5 retries exhausted
    load(0, 'h50, 0, 0, 1, 0, 0, 0);
    nackq.push_back(1); nackq.push_back(1);
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'hA0, "R5");
    ex(BC_CLOSE, -1, "R5"); ex(BC_HOLD, -1, "R5"); ex(BC_OPEN, -1, "R5"); ex(BC_WRITE, 'hA0, "R5");
    ex(BC_CLOSE, -1, "R5");
    run(1, 1, 1, 0, "R5", 0, -1);

    // R4 10-bit write, R7 skip-start message, R9 data NACK
    load(0, 'h1FF, 1, 0, 1, 0, 0, 0);
    load(1, 'h050, 0, 0, 2, 0, 1, 0);
    txq.push_back(8'h01); txq.push_back(8'h02); txq.push_back(8'h03);
    nackq.push_back(0); nackq.push_back(0); nackq.push_back(0); nackq.push_back(1);
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'hF2, "R4"); ex(BC_WRITE, 'hFF, "R4");
    ex(BC_WRITE, 'h01, "R12"); ex(BC_WRITE, 'h02, "R7"); ex(BC_CLOSE, -1, "R9");
    run(2, 0, 2, 1, "R9", 0, -1);

    // R6 ignore-NACK: one attempt, NACKs tolerated
    load(0, 'h50, 0, 0, 1, 1, 0, 0);
    txq.push_back(8'h5A);
    nackq.push_back(1); nackq.push_back(1);
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'hA0, "R6"); ex(BC_WRITE, 'h5A, "R6");
    ex(BC_CLOSE, -1, "R6");
    run(1, 3, 0, 1, "R6", 0, -1);

    // R11 reopen between messages, R8 read without acknowledge clocks
    load(0, 'h10, 0, 0, 1, 0, 0, 0);
    load(1, 'h10, 0, 1, 2, 0, 0, 1);
    txq.push_back(8'h77);
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'h20, "R3"); ex(BC_WRITE, 'h77, "R12");
    ex(BC_REOPEN, -1, "R11"); ex(BC_WRITE, 'h21, "R3");
    ex(BC_READ, -1, "R8"); ex(BC_READ, -1, "R8"); ex(BC_CLOSE, -1, "R11");
    erx.push_back(8'h30); erx.push_back(8'h31);
    run(2, 0, 0, 2, "R11", 0, -1);

    // R10 timeout on the address byte
    load(0, 'h50, 0, 0, 1, 0, 0, 0);
    txq.push_back(8'h99);
    to_at = 2;
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'hA0, "R10"); ex(BC_CLOSE, -1, "R10");
    run(1, 0, 3, 0, "R10", 0, -1);

    // R12 write waits for an empty transmit stream
    load(0, 'h50, 0, 0, 1, 0, 0, 0);
    ex(BC_OPEN, -1, "R11"); ex(BC_WRITE, 'hA0, "R3"); ex(BC_WRITE, 'h3C, "R12");
    ex(BC_CLOSE, -1, "R11");
    run(1, 0, 0, 1, "R12", 0, 'h3C);

    // R11 zero messages
    ex(BC_OPEN, -1, "R11"); ex(BC_CLOSE, -1, "R11");
    run(0, 0, 0, 0, "R11", 0, -1);

    summary();
    $finish;
  end
endmodule